// File: doc/BRIEF.md
# Pixel-to-Lane Serializer for Flat-Panel Links

This block turns one parallel pixel into a seven-slot serial frame on four data lanes and one clock lane. Each pixel carries 8-bit red, green and blue values plus horizontal sync, vertical sync and a data-valid flag. The block runs on a single fast clock at seven times the pixel rate. It emits one bit per lane on each tick and raises a slot-start strobe during the first slot of every frame.

A two-bit selector picks one of three color layouts: a narrow 18-bit layout on three lanes, and two 24-bit layouts that differ in which color bits travel on the fourth lane. A mirror input reverses the slot order on every data lane. Inputs are sampled once per frame, at the tick that ends slot 6, so a source may change them at any time and the frame being sent is never disturbed. The clock lane repeats a fixed seven-slot pattern that does not depend on the mode or the mirror setting.

The source must hold the pixel stable until the end of slot 6. The simplest way is to present a new pixel after each slot-start strobe.

Top module: `lvds_lane_serializer`

## Requirements
- R1: A slot counter runs 0,1,...,6,0,...; `slotStart` is high exactly in slot 0, and the first cycle after reset is slot 0.
- R2: `laneClk` is 1 in slots 0, 1, 5 and 6 and 0 in slots 2, 3 and 4, whatever the mode and the mirror setting.
- R3: With `mapSel` 2'b00 or 2'b11 (narrow mode), with c = color[7:2] and slot order 0..6: lane 0 is G0,R5,R4,R3,R2,R1,R0; lane 1 is B1,B0,G5,G4,G3,G2,G1; lane 2 is DE,VS,HS,B5,B4,B3,B2.
- R4: In narrow mode lane 3 stays 0, and color bits [1:0] have no effect on any lane.
- R5: On lane 2, slot 0 carries data enable, slot 1 vertical sync and slot 2 horizontal sync. Slot 0 of lane 3 is always 0.
- R6: With `mapSel` 2'b01, lanes 0-2 follow the R3 layout using color[7:2], and lane 3 is 0,B1,B0,G1,G0,R1,R0 (8-bit indices).
- R7: With `mapSel` 2'b10, lanes 0-2 follow the R3 layout using color[5:0], and lane 3 is 0,B7,B6,G7,G6,R7,R6.
- R8: With `mirrorEn` captured as 1, every data lane sends the layout slots in the order 6 down to 0.
- R9: Pixel, `mapSel` and `mirrorEn` are captured only at the clock edge that ends slot 6. Changes at other times do not alter the frame being sent.
- R10: Synchronous active-high `rst` returns the counter to slot 0 and drives all data lanes to 0. The lanes stay 0 for the whole first frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven ticks per pixel |
| rst | input | 1 | Synchronous active-high reset |
| pixRed | input | 8 | Red component |
| pixGreen | input | 8 | Green component |
| pixBlue | input | 8 | Blue component |
| pixHsync | input | 1 | Horizontal sync |
| pixVsync | input | 1 | Vertical sync |
| pixDe | input | 1 | Data enable |
| mapSel | input | 2 | Color layout: 00 narrow, 01 wide-A, 10 wide-B, 11 as narrow |
| mirrorEn | input | 1 | Reverse slot order on data lanes |
| laneData | output | 4 | Serial bit of data lanes 3..0 |
| laneClk | output | 1 | Clock lane bit |
| slotStart | output | 1 | High during slot 0 |

## Verification
The hardest case to reach is an input change in the middle of a frame, which must not leak into the bits still being sent. The stimulus places a second random pixel, mode and mirror setting at slot 3 of many frames. It then expects the current frame to be unchanged and the next frame to carry only the value present at the capture edge. A reset in the middle of a frame, followed by an all-zero frame, covers the restart of the slot counter.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int SLOT_W  = $clog2(SLOTS);

  typedef enum logic [1:0] {
    MAP_NARROW = 2'b00,
    MAP_WIDE_A = 2'b01,
    MAP_WIDE_B = 2'b10,
    MAP_SPARE  = 2'b11
  } map_e;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
    logic               hsync;
    logic               vsync;
    logic               de;
  } pixel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
  } slot_ctrl_t;

endpackage

// File: rtl/lvds_ser_ctrl.sv
module lvds_ser_ctrl
  import lvds_ser_pkg::*;
#(
  parameter int NSLOT    = SLOTS,
  parameter int CLK_HEAD = 2,
  parameter int CLK_TAIL = 2
) (
  input  logic       clk,
  input  logic       rst,
  output slot_ctrl_t ctrlO,
  output logic       slotStartO,
  output logic       laneClkO
);

  localparam int CW = $clog2(NSLOT);
  localparam logic [CW-1:0] LAST      = CW'(NSLOT - 1);
  localparam logic [CW-1:0] HEAD_END  = CW'(CLK_HEAD);
  localparam logic [CW-1:0] TAIL_BEG  = CW'(NSLOT - CLK_TAIL);

  logic [CW-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (rst)                 slotCnt <= '0;
    else if (slotCnt == LAST) slotCnt <= '0;
    else                     slotCnt <= slotCnt + 1'b1;
  end

  always_comb begin
    ctrlO.load = (slotCnt == LAST);
    ctrlO.slot = slotCnt;
  end

  assign slotStartO = (slotCnt == '0);
  assign laneClkO   = (slotCnt < HEAD_END) || (slotCnt >= TAIL_BEG);

  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    slotCnt <= LAST);  // R1
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    slotCnt == LAST |=> slotStartO);  // R1
  AST_CLK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(laneClkO) |-> slotCnt == TAIL_BEG);  // R2

endmodule

// File: rtl/lvds_ser_mapper.sv
module lvds_ser_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t                      pixI,
  input  map_e                        modeI,
  output logic [LANES-1:0][SLOTS-1:0] wordO
);

  localparam int NARROW_W = 6;

  logic [NARROW_W-1:0] r6, g6, b6;
  logic [2:0]          ctl;
  logic [1:0]          rPair, gPair, bPair;
  logic                wideMode, upperPair;

  assign upperPair = (modeI == MAP_WIDE_B);
  assign wideMode  = (modeI == MAP_WIDE_A) || (modeI == MAP_WIDE_B);

  // narrow / wide-A use the top six bits, wide-B the bottom six
  assign r6 = upperPair ? pixI.red[5:0]   : pixI.red[7:2];
  assign g6 = upperPair ? pixI.green[5:0] : pixI.green[7:2];
  assign b6 = upperPair ? pixI.blue[5:0]  : pixI.blue[7:2];

  // fourth lane carries whichever pair the first three lanes left out
  assign rPair = wideMode ? (upperPair ? pixI.red[7:6]   : pixI.red[1:0])   : 2'b00;
  assign gPair = wideMode ? (upperPair ? pixI.green[7:6] : pixI.green[1:0]) : 2'b00;
  assign bPair = wideMode ? (upperPair ? pixI.blue[7:6]  : pixI.blue[1:0])  : 2'b00;

  // slot 0 = data enable, 1 = vsync, 2 = hsync
  assign ctl = {pixI.de, pixI.vsync, pixI.hsync};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_l0a
      assign wordO[0][s] = g6[0];
    end else begin : g_l0b
      assign wordO[0][s] = r6[6-s];
    end

    if (s < 2) begin : g_l1a
      assign wordO[1][s] = b6[1-s];
    end else begin : g_l1b
      assign wordO[1][s] = g6[7-s];
    end

    if (s < 3) begin : g_l2a
      assign wordO[2][s] = ctl[2-s];
    end else begin : g_l2b
      assign wordO[2][s] = b6[8-s];
    end

    if (s == 0) begin : g_l3z
      assign wordO[3][s] = 1'b0;
    end else if (s < 3) begin : g_l3b
      assign wordO[3][s] = bPair[2-s];
    end else if (s < 5) begin : g_l3g
      assign wordO[3][s] = gPair[4-s];
    end else begin : g_l3r
      assign wordO[3][s] = rPair[6-s];
    end
  end

endmodule

// File: rtl/lvds_ser_datapath.sv
module lvds_ser_datapath
  import lvds_ser_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  slot_ctrl_t                  ctrlI,
  input  logic [LANES-1:0][SLOTS-1:0] wordI,
  input  map_e                        modeI,
  input  logic                        mirrorI,
  output logic [LANES-1:0]            laneDataO
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [LANES-1:0][SLOTS-1:0] wordQ;
  logic                        mirrorQ;
  logic [SLOT_W-1:0]           pickIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ   <= '0;
      mirrorQ <= 1'b0;
    end else if (ctrlI.load) begin
      wordQ   <= wordI;
      mirrorQ <= mirrorI;
    end
  end

  assign pickIdx = mirrorQ ? (LAST - ctrlI.slot) : ctrlI.slot;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneDataO[l] = wordQ[l][pickIdx];
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrlI.load |=> $stable(wordQ) && $stable(mirrorQ));  // R9
  AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (rst)
    ctrlI.load && (modeI == MAP_NARROW || modeI == MAP_SPARE) |=> wordQ[3] == '0);  // R4
  AST_CTL3_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrlI.load |=> !wordQ[3][0]);  // R5

endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer
  import lvds_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pixRed,
  input  logic [7:0] pixGreen,
  input  logic [7:0] pixBlue,
  input  logic       pixHsync,
  input  logic       pixVsync,
  input  logic       pixDe,
  input  logic [1:0] mapSel,
  input  logic       mirrorEn,
  output logic [3:0] laneData,
  output logic       laneClk,
  output logic       slotStart
);

  slot_ctrl_t                  ctrl;
  pixel_t                      pix;
  map_e                        mode;
  logic [LANES-1:0][SLOTS-1:0] mappedWord;

  assign pix  = '{red: pixRed, green: pixGreen, blue: pixBlue,
                  hsync: pixHsync, vsync: pixVsync, de: pixDe};
  assign mode = map_e'(mapSel);

  lvds_ser_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrlO      (ctrl),
    .slotStartO (slotStart),
    .laneClkO   (laneClk)
  );

  lvds_ser_mapper u_map (
    .pixI  (pix),
    .modeI (mode),
    .wordO (mappedWord)
  );

  lvds_ser_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrlI     (ctrl),
    .wordI     (mappedWord),
    .modeI     (mode),
    .mirrorI   (mirrorEn),
    .laneDataO (laneData)
  );

endmodule

// File: tb/lvds_lane_serializer_tb.sv
module lvds_lane_serializer_tb;

  typedef struct packed {
    logic [7:0] r, g, b;
    logic       hs, vs, de;
    logic [1:0] md;
    logic       mir;
  } stim_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pixRed = '0, pixGreen = '0, pixBlue = '0;
  logic       pixHsync = 1'b0, pixVsync = 1'b0, pixDe = 1'b0;
  logic [1:0] mapSel = '0;
  logic       mirrorEn = 1'b0;
  logic [3:0] laneData;
  logic       laneClk, slotStart;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  stim_t cur, applied;
  bit    curZero = 1;
  bit    glitchNow = 0;

  always #4 clk = ~clk;

  lvds_lane_serializer u_dut (
    .clk(clk), .rst(rst), .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
    .pixHsync(pixHsync), .pixVsync(pixVsync), .pixDe(pixDe), .mapSel(mapSel),
    .mirrorEn(mirrorEn), .laneData(laneData), .laneClk(laneClk), .slotStart(slotStart)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected lane content, index = slot in unmirrored order
  function automatic logic [6:0] expLane(stim_t p, int lane);
    logic [5:0] r6, g6, b6;
    logic [6:0] w;
    if (p.md == 2'b10) begin
      r6 = p.r[5:0]; g6 = p.g[5:0]; b6 = p.b[5:0];
    end else begin
      r6 = p.r[7:2]; g6 = p.g[7:2]; b6 = p.b[7:2];
    end
    case (lane)
      0: w = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
      1: w = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
      2: w = {b6[2], b6[3], b6[4], b6[5], p.hs, p.vs, p.de};
      default: begin
        case (p.md)
          2'b01:   w = {p.r[0], p.r[1], p.g[0], p.g[1], p.b[0], p.b[1], 1'b0};
          2'b10:   w = {p.r[6], p.r[7], p.g[6], p.g[7], p.b[6], p.b[7], 1'b0};
          default: w = '0;
        endcase
      end
    endcase
    return w;
  endfunction

  function automatic string tagFor(int lane, int s, int idx);
    if (curZero) return "R10";
    if (glitchNow && s > 3) return "R9";
    if (cur.mir) return "R8";
    if ((lane == 2 && idx < 3) || (lane == 3 && idx == 0)) return "R5";
    case (cur.md)
      2'b01: return "R6";
      2'b10: return "R7";
      default: return (lane == 3) ? "R4" : "R3";
    endcase
  endfunction

  function automatic stim_t randStim();
    stim_t t;
    t.r = 8'($urandom); t.g = 8'($urandom); t.b = 8'($urandom);
    t.hs = 1'($urandom); t.vs = 1'($urandom); t.de = 1'($urandom);
    t.md = 2'($urandom_range(0, 3));
    t.mir = 1'($urandom_range(0, 1));
    return t;
  endfunction

  task automatic drive(input stim_t t);
    pixRed = t.r; pixGreen = t.g; pixBlue = t.b;
    pixHsync = t.hs; pixVsync = t.vs; pixDe = t.de;
    mapSel = t.md; mirrorEn = t.mir;
    applied = t;
  endtask

  // starts at the falling edge inside slot 0, ends at the next slot 0
  task automatic runPeriod(input stim_t nxt, input bit glitch, input stim_t alt);
    glitchNow = glitch;
    for (int s = 0; s < 7; s++) begin
      chk(slotStart == (s == 0), "R1", "slotStart", slotStart, (s == 0));
      chk(laneClk == ((s < 2) || (s > 4)), "R2", "laneClk", laneClk, ((s < 2) || (s > 4)));
      for (int l = 0; l < 4; l++) begin
        int idx;
        logic expBit;
        idx = cur.mir ? 6 - s : s;
        expBit = curZero ? 1'b0 : expLane(cur, l)[idx];
        chk(laneData[l] == expBit, tagFor(l, s, idx), $sformatf("lane%0d slot%0d", l, s),
            laneData[l], expBit);
      end
      if (s == 0) drive(nxt);
      if (s == 3 && glitch) drive(alt);
      @(negedge clk);
    end
    cur = applied;
    curZero = 0;
    glitchNow = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    drive(randStim());
    repeat (3) @(negedge clk);
    chk(laneData == 4'b0, "R10", "data in reset", laneData, 0);
    chk(slotStart == 1'b1, "R1", "slot0 in reset", slotStart, 1);
    rst = 1'b0;
    curZero = 1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    stim_t a, b;
    void'($urandom(32'h5eed));
    @(negedge clk);
    doReset();
    // directed corners
    a = '{r: 8'hFF, g: 8'hFF, b: 8'hFF, hs: 1, vs: 1, de: 1, md: 2'b00, mir: 0};
    runPeriod(a, 0, a);
    a = '{r: 8'hA5, g: 8'h3C, b: 8'hC3, hs: 1, vs: 0, de: 1, md: 2'b01, mir: 0};
    runPeriod(a, 0, a);
    a = '{r: 8'h5A, g: 8'hC3, b: 8'h3C, hs: 0, vs: 1, de: 0, md: 2'b10, mir: 0};
    runPeriod(a, 0, a);
    a = '{r: 8'h03, g: 8'h03, b: 8'h03, hs: 0, vs: 0, de: 1, md: 2'b11, mir: 1};
    runPeriod(a, 0, a);
    a = '{r: 8'h81, g: 8'h42, b: 8'h24, hs: 1, vs: 1, de: 0, md: 2'b10, mir: 1};
    runPeriod(a, 0, a);
    a = '{r: 8'h00, g: 8'h00, b: 8'h00, hs: 0, vs: 0, de: 0, md: 2'b01, mir: 1};
    runPeriod(a, 0, a);
    // random with mid-frame changes
    for (int k = 0; k < 200; k++) begin
      a = randStim();
      b = randStim();
      runPeriod(a, 1'($urandom_range(0, 1)), b);
    end
    // reset in the middle of a frame
    repeat (3) @(negedge clk);
    doReset();
    for (int k = 0; k < 20; k++) begin
      a = randStim();
      b = randStim();
      runPeriod(a, 1'($urandom_range(0, 1)), b);
    end
    finishRun();
  end

endmodule